// File: doc/BRIEF.md
# Filtered Taken-Transfer Record Stack

This block keeps a short history of recent taken control transfers: jumps, calls, returns, far transfers, interrupts and exceptions. Each retired transfer arrives as one event carrying its source address, its destination address, a three-bit kind code and a two-bit privilege level. An event that passes the filters is written into a 16-entry circular store. A 4-bit top pointer names the newest entry. When the store is full, each new record replaces the oldest one.

Software controls capture through two registers on one write port. The filter register has one suppress bit per transfer class and two privilege suppress bits. The control register holds a global recording enable. A combinational read port returns the address pair held in any slot. The pointer and both registers are always visible.

Top module: `xfer_trail`

## Requirements
- R1: After reset `tosQ` is 0, `selQ` is 0 and `ctrlQ` is 0, so recording is off.
- R2: With recording on, an accepted event on `evValid` at a clock edge makes `tosQ` equal to the old value plus 1 after that edge. The slot that `tosQ` now names holds the event's `evFrom` in `rdFrom` and its `evTo` in `rdTo`.
- R3: The pointer wraps from 15 to 0. After more than 16 accepted events, the slots hold the 16 most recent records, and the older contents are overwritten.
- R4: The kind codes are 0 conditional, 1 near relative call, 2 near indirect call, 3 near return, 4 near indirect jump, 5 near relative jump, 6 far branch and 7 interrupt or exception. Filter bit (code + 2) suppresses codes 0 to 6. Filter bit 8 suppresses both code 6 and code 7.
- R5: Filter bit 0 suppresses events whose `evPriv` is 0. Filter bit 1 suppresses events whose `evPriv` is 1, 2 or 3.
- R6: Control bit 0 enables recording. While it is 0, every event is dropped.
- R7: A write with `cfgSel`=0 loads filter bits 8:0. Bits 63:9 of that write are discarded and read as 0 on `selQ`. A write with `cfgSel`=1 loads only control bit 0, and `ctrlQ` bits 63:1 read as 0.
- R8: A dropped event changes neither `tosQ` nor the contents of any slot.
- R9: A register write takes effect from the next edge. An event in the same cycle as the write is filtered by the values held before the write.
- R10: `rdFrom` and `rdTo` show the slot selected by `rdIdx` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 1 | Write target: 0 filter, 1 control |
| cfgWdata | input | 64 | Write data |
| selQ | output | 64 | Filter register readback |
| ctrlQ | output | 64 | Control register readback |
| evValid | input | 1 | Transfer event present this cycle |
| evFrom | input | ADDR_W | Source address of the transfer |
| evTo | input | ADDR_W | Destination address of the transfer |
| evKind | input | 3 | Transfer kind code |
| evPriv | input | 2 | Privilege level of the transfer |
| rdIdx | input | 4 | Slot to read |
| rdFrom | output | ADDR_W | Source address held in slot `rdIdx` |
| rdTo | output | ADDR_W | Destination address held in slot `rdIdx` |
| tosQ | output | 4 | Index of the newest record |

## Verification
A register write and an event can arrive in the same cycle. In that case, which filter value applies decides whether the event is recorded. The bench drives a filter write that suppresses conditional branches together with a conditional-branch event. It expects the event to be recorded under the old filter and the next conditional branch to be dropped. It also clears the enable together with an event, and expects that event to be kept and the next one to be lost.

// File: rtl/xfer_trail_pkg.sv
package xfer_trail_pkg;

  localparam int TRAIL_DEPTH = 16;
  localparam int PTR_W       = $clog2(TRAIL_DEPTH);
  localparam int REG_W       = 64;
  localparam int SEL_USED    = 9;
  localparam int KIND_W      = 3;
  localparam int PRIV_W      = 2;

  localparam logic [REG_W-1:0] SEL_KEEP  = {{(REG_W-SEL_USED){1'b0}}, {SEL_USED{1'b1}}};
  localparam logic [REG_W-1:0] CTRL_KEEP = {{(REG_W-1){1'b0}}, 1'b1};

  typedef enum logic [KIND_W-1:0] {
    K_COND  = 3'd0,
    K_RCALL = 3'd1,
    K_ICALL = 3'd2,
    K_RET   = 3'd3,
    K_IJMP  = 3'd4,
    K_RJMP  = 3'd5,
    K_FAR   = 3'd6,
    K_INTR  = 3'd7
  } kind_e;

  localparam int PRIV0_BIT = 0;
  localparam int PRIVN_BIT = 1;

  typedef struct packed {
    logic             push;
    logic [PTR_W-1:0] slot;
  } trail_strobe_t;

  function automatic int unsigned kindMaskBit(input logic [KIND_W-1:0] k);
    if (k == K_INTR) return 8;
    return 32'(k) + 2;
  endfunction

endpackage

// File: rtl/xfer_trail_ctrl.sv
module xfer_trail_ctrl
  import xfer_trail_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 cfgSel,
  input  logic [REG_W-1:0]     cfgWdata,
  input  logic                 evValid,
  input  logic [KIND_W-1:0]    evKind,
  input  logic [PRIV_W-1:0]    evPriv,
  output logic [REG_W-1:0]     selQ,
  output logic [REG_W-1:0]     ctrlQ,
  output logic [PTR_W-1:0]     tosQ,
  output trail_strobe_t        strobe
);

  logic [REG_W-1:0] selReg;
  logic [REG_W-1:0] ctrlReg;
  logic [PTR_W-1:0] tosReg;
  logic             classBlock;
  logic             privBlock;
  logic             recOn;
  logic             accept;

  always_comb begin
    classBlock = selReg[kindMaskBit(evKind)];
    privBlock  = (evPriv == '0) ? selReg[PRIV0_BIT] : selReg[PRIVN_BIT];
    recOn      = ctrlReg[0];
    accept     = evValid && recOn && !classBlock && !privBlock;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg  <= '0;
      ctrlReg <= '0;
      tosReg  <= '0;
    end else begin
      if (cfgWe && !cfgSel) selReg  <= cfgWdata & SEL_KEEP;
      if (cfgWe && cfgSel)  ctrlReg <= cfgWdata & CTRL_KEEP;
      if (accept)           tosReg  <= tosReg + 1'b1;
    end
  end

  assign strobe.push = accept;
  assign strobe.slot = tosReg + 1'b1;
  assign selQ  = selReg;
  assign ctrlQ = ctrlReg;
  assign tosQ  = tosReg;

  a_r2_tos_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> tosQ == $past(tosQ) + 1'b1);

  a_r8_tos_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.push |=> $stable(tosQ));

  a_r6_off_drops: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[0] && evValid) |=> $stable(tosQ));

  a_r7_sel_masked: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgSel) |=> selQ == ($past(cfgWdata) & SEL_KEEP));

  a_r7_ctrl_masked: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel) |=> ctrlQ == ($past(cfgWdata) & CTRL_KEEP));

endmodule

// File: rtl/xfer_trail_data.sv
module xfer_trail_data
  import xfer_trail_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trail_strobe_t     strobe,
  input  logic [ADDR_W-1:0] evFrom,
  input  logic [ADDR_W-1:0] evTo,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] rdFrom,
  output logic [ADDR_W-1:0] rdTo
);

  localparam int REC_W = 2 * ADDR_W;

  logic [REC_W-1:0] slotMem [TRAIL_DEPTH];

  for (genvar g = 0; g < TRAIL_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && strobe.slot == PTR_W'(g))
        slotMem[g] <= {evFrom, evTo};
    end
  end

  always_comb begin
    rdFrom = slotMem[rdIdx][REC_W-1:ADDR_W];
    rdTo   = slotMem[rdIdx][ADDR_W-1:0];
  end

  a_r2_slot_written: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> slotMem[$past(strobe.slot)] == {$past(evFrom), $past(evTo)});

endmodule

// File: rtl/xfer_trail.sv
module xfer_trail
  import xfer_trail_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [63:0]       cfgWdata,
  output logic [63:0]       selQ,
  output logic [63:0]       ctrlQ,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evFrom,
  input  logic [ADDR_W-1:0] evTo,
  input  logic [2:0]        evKind,
  input  logic [1:0]        evPriv,
  input  logic [3:0]        rdIdx,
  output logic [ADDR_W-1:0] rdFrom,
  output logic [ADDR_W-1:0] rdTo,
  output logic [3:0]        tosQ
);

  trail_strobe_t strobe;

  xfer_trail_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .evValid  (evValid),
    .evKind   (evKind),
    .evPriv   (evPriv),
    .selQ     (selQ),
    .ctrlQ    (ctrlQ),
    .tosQ     (tosQ),
    .strobe   (strobe)
  );

  xfer_trail_data #(.ADDR_W(ADDR_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .evFrom (evFrom),
    .evTo   (evTo),
    .rdIdx  (rdIdx),
    .rdFrom (rdFrom),
    .rdTo   (rdTo)
  );

endmodule

// File: tb/xfer_trail_bench.sv
`timescale 1ns/1ps
module xfer_trail_bench;

  localparam int AW    = 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWe;
  logic          cfgSel;
  logic [63:0]   cfgWdata;
  logic [63:0]   selQ;
  logic [63:0]   ctrlQ;
  logic          evValid;
  logic [AW-1:0] evFrom;
  logic [AW-1:0] evTo;
  logic [2:0]    evKind;
  logic [1:0]    evPriv;
  logic [3:0]    rdIdx;
  logic [AW-1:0] rdFrom;
  logic [AW-1:0] rdTo;
  logic [3:0]    tosQ;

  always #2 clk = ~clk;

  xfer_trail #(.ADDR_W(AW)) u_xfer_trail (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .selQ(selQ), .ctrlQ(ctrlQ), .evValid(evValid), .evFrom(evFrom), .evTo(evTo),
    .evKind(evKind), .evPriv(evPriv), .rdIdx(rdIdx), .rdFrom(rdFrom), .rdTo(rdTo),
    .tosQ(tosQ)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW-1:0] mFrom [DEPTH];
  logic [AW-1:0] mTo   [DEPTH];
  bit            mValid[DEPTH];
  int            mTos;
  logic [63:0]   mSel;
  bit            mEn;
  int unsigned   seqNo = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit modelPass(input logic [2:0] k, input logic [1:0] p);
    int unsigned b;
    b = (k == 3'd7) ? 8 : 32'(k) + 2;
    return mEn && !mSel[b] && !((p == 2'd0) ? mSel[0] : mSel[1]);
  endfunction

  task automatic cfgWrite(input bit which, input logic [63:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = which; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!which) mSel = d & 64'h1FF; else mEn = d[0];
  endtask

  task automatic send(input logic [2:0] k, input logic [1:0] p);
    logic [AW-1:0] f, t;
    seqNo++;
    f = 32'h1000_0000 + seqNo * 4;
    t = 32'h2000_0000 + seqNo * 8;
    @(negedge clk);
    evValid = 1'b1; evFrom = f; evTo = t; evKind = k; evPriv = p;
    @(negedge clk);
    evValid = 1'b0;
    if (modelPass(k, p)) begin
      mTos = (mTos + 1) % DEPTH;
      mFrom[mTos] = f; mTo[mTos] = t; mValid[mTos] = 1'b1;
    end
  endtask

  // Checks pointer and every written slot through the read port (R10).
  task automatic checkState(input string req);
    bit ok;
    int bad;
    logic [63:0] actV, expV;
    chk(tosQ == 4'(mTos), {req, " tos"}, 64'(tosQ), 64'(mTos));
    ok = 1'b1; bad = -1; actV = '0; expV = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = 4'(i);
      #0.1;
      if (mValid[i] && (rdFrom !== mFrom[i] || rdTo !== mTo[i]) && ok) begin
        ok = 1'b0; bad = i;
        actV = {rdFrom, rdTo}; expV = {mFrom[i], mTo[i]};
      end
    end
    chk(ok, $sformatf("%s R10 slot %0d", req, bad), actV, expV);
  endtask

  task automatic t_reset;
    chk(tosQ == 4'd0, "R1 tos", 64'(tosQ), 0);
    chk(selQ == 64'd0, "R1 sel", selQ, 0);
    chk(ctrlQ == 64'd0, "R1 ctrl", ctrlQ, 0);
  endtask

  task automatic t_disabled;
    send(3'd0, 2'd3);
    send(3'd7, 2'd0);
    checkState("R6 disabled R8");
  endtask

  task automatic t_basic;
    cfgWrite(1'b1, 64'h1);
    chk(ctrlQ == 64'h1, "R6 enable", ctrlQ, 64'h1);
    send(3'd0, 2'd3);
    checkState("R2 first");
    send(3'd3, 2'd0);
    send(3'd6, 2'd2);
    checkState("R2 several");
  endtask

  task automatic t_class_mask;
    for (int k = 0; k < 8; k++) begin
      int b;
      b = (k == 7) ? 8 : k + 2;
      cfgWrite(1'b0, 64'h1 << b);
      send(3'(k), 2'd3);
      send(3'((k + 1) % 8), 2'd3);
      checkState($sformatf("R4 mask kind %0d R8", k));
    end
  endtask

  task automatic t_priv;
    cfgWrite(1'b0, 64'h1);
    send(3'd1, 2'd0);
    send(3'd1, 2'd3);
    checkState("R5 priv0 blocked");
    cfgWrite(1'b0, 64'h2);
    send(3'd2, 2'd1);
    send(3'd2, 2'd2);
    send(3'd2, 2'd0);
    checkState("R5 priv nonzero blocked");
  endtask

  task automatic t_reserved;
    cfgWrite(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(selQ == 64'h1FF, "R7 sel reserved", selQ, 64'h1FF);
    cfgWrite(1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    chk(ctrlQ == 64'h0, "R7 ctrl reserved", ctrlQ, 64'h0);
    cfgWrite(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(ctrlQ == 64'h1, "R7 ctrl bit0", ctrlQ, 64'h1);
    cfgWrite(1'b0, 64'hDEAD_0000_0000_0000);
    chk(selQ == 64'h0, "R7 sel cleared", selQ, 64'h0);
  endtask

  task automatic t_wrap;
    int start;
    start = mTos;
    for (int i = 0; i < 20; i++) send(3'(i % 8), 2'(i % 4));
    chk(tosQ == 4'((start + 20) % DEPTH), "R3 wrap tos", 64'(tosQ), 64'((start + 20) % DEPTH));
    checkState("R3 overwrite");
  endtask

  task automatic t_same_cycle;
    logic [AW-1:0] f;
    seqNo++;
    f = 32'h3000_0000 + seqNo;
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 1'b0; cfgWdata = 64'h4;
    evValid = 1'b1; evFrom = f; evTo = ~f; evKind = 3'd0; evPriv = 2'd3;
    @(negedge clk);
    cfgWe = 1'b0; evValid = 1'b0;
    mTos = (mTos + 1) % DEPTH;
    mFrom[mTos] = f; mTo[mTos] = ~f; mValid[mTos] = 1'b1;
    mSel = 64'h4;
    checkState("R9 old filter applies");
    send(3'd0, 2'd3);
    checkState("R9 new filter applies");
    seqNo++;
    f = 32'h4000_0000 + seqNo;
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 1'b1; cfgWdata = 64'h0;
    evValid = 1'b1; evFrom = f; evTo = ~f; evKind = 3'd4; evPriv = 2'd0;
    @(negedge clk);
    cfgWe = 1'b0; evValid = 1'b0;
    mTos = (mTos + 1) % DEPTH;
    mFrom[mTos] = f; mTo[mTos] = ~f; mValid[mTos] = 1'b1;
    mEn = 1'b0;
    send(3'd4, 2'd0);
    checkState("R9 R6 enable cleared");
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgSel = 1'b0; cfgWdata = '0;
    evValid = 1'b0; evFrom = '0; evTo = '0; evKind = '0; evPriv = '0; rdIdx = '0;
    mTos = 0; mSel = '0; mEn = 1'b0;
    for (int i = 0; i < DEPTH; i++) mValid[i] = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_class_mask();
    t_priv();
    t_reserved();
    t_wrap();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule